// File: doc/BRIEF.md
# Parallel Flash Single-Byte Program Controller

This block sits on the host side of an asynchronous parallel NOR flash and writes one byte into it. A request carries a target address and a data byte. The controller first reads the target location. If the new byte needs any bit to go from 0 to 1, it refuses the request, because only an erase can do that. Otherwise it issues the three-write unlock preamble and the program write. It then reads the target repeatedly until bit 7 shows the true data. A final full-byte read confirms the result.

All flash strobes are active low. Every strobe width is a count of clock cycles set by a parameter. The data bus is split into an output value, an output enable and an input value, and the pad logic around the block builds the tri-state from these. The controller handles one request at a time. A pulse on `done` or `err` ends each request, and `err_code` gives the reason for an error.

The state machine has these states:

| State | What it does |
|-------|--------------|
| `ST_IDLE` | Waits for a request. |
| `ST_PRE_RD` | Reads the target location. |
| `ST_PRE_CHK` | Checks whether the new byte can be written over the old one. |
| `ST_WR_SETUP` | Presents address and data with WE high. |
| `ST_WR_PULSE` | Holds WE low. |
| `ST_WR_REC` | Holds WE high with address and data still driven. |
| `ST_POLL_RD` | Reads the target during polling. |
| `ST_POLL_EVAL` | Tests bit 7 of the polling read. |
| `ST_VFY_RD` | Reads the target for the final check. |
| `ST_VFY_EVAL` | Compares the whole byte. |
| `ST_DONE` | Signals success for one cycle. |
| `ST_FAIL` | Signals an error for one cycle. |

The transitions are:

- `ST_IDLE` goes to `ST_PRE_RD` when a request arrives.
- `ST_PRE_RD` goes to `ST_PRE_CHK` when the read timer expires.
- `ST_PRE_CHK` goes to `ST_FAIL` if an erase would be needed, and to `ST_WR_SETUP` otherwise.
- `ST_WR_SETUP` goes to `ST_WR_PULSE`.
- `ST_WR_PULSE` goes to `ST_WR_REC` when the low timer expires.
- `ST_WR_REC` goes back to `ST_WR_SETUP` for the next write. After the fourth write it goes to `ST_POLL_RD`.
- `ST_POLL_RD` goes to `ST_POLL_EVAL`.
- `ST_POLL_EVAL` goes to `ST_VFY_RD` when bit 7 matches, to `ST_FAIL` on timeout, and back to `ST_POLL_RD` otherwise.
- `ST_VFY_RD` goes to `ST_VFY_EVAL`.
- `ST_VFY_EVAL` goes to `ST_DONE` on a match and to `ST_FAIL` otherwise.
- `ST_DONE` and `ST_FAIL` both go to `ST_IDLE`.

Top module: `flash_byte_prog`

## Requirements
- R1: In reset and while idle: `fl_ce_n`, `fl_oe_n` and `fl_we_n` are high, `fl_dq_oe` is low, and `busy`, `done` and `err` are low.
- R2: An accepted request first reads the target with CE and OE low for READ_CYC cycles. If the new byte has a 1 where the stored byte has a 0, `err` rises READ_CYC+2 sampled cycles after acceptance with `err_code` = 1, no WE pulse is issued, and the memory is unchanged.
- R3: A writable byte is programmed by exactly four writes in this order:
  - 0xAA to address 0x555
  - 0x55 to address 0x2AA
  - 0xA0 to address 0x555
  - the request data to the request address

  Unlock addresses have all bits above bit 11 at zero.
- R4: Each WE low pulse lasts exactly WE_LOW_CYC cycles, with CE low, OE high and data driven throughout.
- R5: Between consecutive pulses of one sequence, WE is high for exactly WE_HIGH_CYC+1 cycles. Address and data stay stable from the WE fall through the cycle after the WE rise.
- R6: The data bus is driven only in the write states and never while OE is low.
- R7: After the fourth write, the target is read repeatedly, with OE high for one cycle between reads, for as long as bit 7 differs from bit 7 of the request data.
- R8: Once bit 7 matches, one more full-byte read is made. If it equals the request data, `done` pulses with `err_code` = 0 and the memory holds the new byte.
- R9: If that final byte differs from the request data, `err` pulses with `err_code` = 3.
- R10: If bit 7 still differs once polling has run TIMEOUT_CYC cycles, `err` pulses with `err_code` = 2.
- R11: `req_valid` is ignored while `busy` is high. Such a request causes no write and leaves its location untouched.
- R12: `done` and `err` are one-cycle pulses that never occur together. `busy` is low in the cycle after either pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_addr | input | ADDR_W | Target byte address |
| req_data | input | 8 | Byte to program |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle success pulse |
| err | output | 1 | One-cycle error pulse |
| err_code | output | 2 | Error reason: 0 none, 1 needs erase, 2 timeout, 3 verify mismatch |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_addr | output | ADDR_W | Flash address bus |
| fl_dq_out | output | 8 | Data driven toward the flash |
| fl_dq_oe | output | 1 | Drive enable for the data bus; the bus is high-Z when low |
| fl_dq_in | input | 8 | Data read from the flash |

## Verification
Rejecting a byte that needs an erase has a fixed latency of READ_CYC+2 cycles, and the bench checks that exact count. Latency to `done` or a timeout depends on how long the flash model stays busy. The bench therefore waits for a status pulse, then checks the code, the model's memory, and the number of WE falls. It also checks that `busy` has dropped one cycle later. Pulse widths, the high gaps inside a sequence, address and data hold, and bus contention are measured cycle by cycle by the bench's flash model, which samples at the falling clock edge. Stimulus and reads happen one time unit after that edge, so they never race the model.

// File: rtl/fbp_pkg.sv
package fbp_pkg;

    localparam int unsigned DATA_W    = 8;
    localparam int unsigned KEY_AW    = 12;
    localparam logic [1:0]  LAST_STEP = 2'd3;

    localparam logic [KEY_AW-1:0] KEY_ADDR_A = 12'h555;
    localparam logic [KEY_AW-1:0] KEY_ADDR_B = 12'h2AA;
    localparam logic [DATA_W-1:0] KEY_DATA_A = 8'hAA;
    localparam logic [DATA_W-1:0] KEY_DATA_B = 8'h55;
    localparam logic [DATA_W-1:0] KEY_PROG   = 8'hA0;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE_RD,
        ST_PRE_CHK,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_REC,
        ST_POLL_RD,
        ST_POLL_EVAL,
        ST_VFY_RD,
        ST_VFY_EVAL,
        ST_DONE,
        ST_FAIL
    } fbp_state_e;

    typedef enum logic [1:0] {
        ERR_NONE        = 2'd0,
        ERR_NEEDS_ERASE = 2'd1,
        ERR_TIMEOUT     = 2'd2,
        ERR_VERIFY      = 2'd3
    } fbp_err_e;

endpackage

// File: rtl/fbp_timer.sv
module fbp_timer #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/fbp_cmd_gen.sv
module fbp_cmd_gen
    import fbp_pkg::*;
#(
    parameter int unsigned ADDR_W = 17
) (
    input  logic [1:0]        step,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic [DATA_W-1:0] tgt_data,
    output logic [ADDR_W-1:0] cyc_addr,
    output logic [DATA_W-1:0] cyc_data
);

    localparam int unsigned PAD_W = ADDR_W - KEY_AW;

    always_comb begin
        unique case (step)
            2'd0: begin
                cyc_addr = {{PAD_W{1'b0}}, KEY_ADDR_A};
                cyc_data = KEY_DATA_A;
            end
            2'd1: begin
                cyc_addr = {{PAD_W{1'b0}}, KEY_ADDR_B};
                cyc_data = KEY_DATA_B;
            end
            2'd2: begin
                cyc_addr = {{PAD_W{1'b0}}, KEY_ADDR_A};
                cyc_data = KEY_PROG;
            end
            default: begin
                cyc_addr = tgt_addr;
                cyc_data = tgt_data;
            end
        endcase
    end

endmodule

// File: rtl/fbp_byte_cmp.sv
module fbp_byte_cmp
    import fbp_pkg::*;
(
    input  logic [DATA_W-1:0] want,
    input  logic [DATA_W-1:0] seen,
    output logic              needs_erase,
    output logic              msb_ok,
    output logic              all_ok
);

    always_comb begin
        needs_erase = |(want & ~seen);
        msb_ok      = (want[DATA_W-1] == seen[DATA_W-1]);
        all_ok      = (want == seen);
    end

endmodule

// File: rtl/flash_byte_prog.sv
module flash_byte_prog
    import fbp_pkg::*;
#(
    parameter int unsigned ADDR_W      = 17,
    parameter int unsigned READ_CYC    = 5,
    parameter int unsigned WE_LOW_CYC  = 3,
    parameter int unsigned WE_HIGH_CYC = 3,
    parameter int unsigned TIMEOUT_CYC = 6000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [1:0]        err_code,
    output logic              fl_ce_n,
    output logic              fl_oe_n,
    output logic              fl_we_n,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [DATA_W-1:0] fl_dq_out,
    output logic              fl_dq_oe,
    input  logic [DATA_W-1:0] fl_dq_in
);

    localparam int unsigned T_AB  = (READ_CYC > WE_LOW_CYC) ? READ_CYC : WE_LOW_CYC;
    localparam int unsigned T_MAX = (T_AB > WE_HIGH_CYC) ? T_AB : WE_HIGH_CYC;
    localparam int unsigned TW    = $clog2(T_MAX + 1);
    localparam int unsigned PW    = $clog2(TIMEOUT_CYC + 1) + 1;

    localparam logic [TW-1:0] RD_LOAD = TW'(READ_CYC - 1);
    localparam logic [TW-1:0] LO_LOAD = TW'(WE_LOW_CYC - 1);
    localparam logic [TW-1:0] HI_LOAD = TW'(WE_HIGH_CYC - 1);
    localparam logic [PW-1:0] TO_LIM  = PW'(TIMEOUT_CYC);

    fbp_state_e        state_q, state_d;
    fbp_err_e          err_q;
    logic [ADDR_W-1:0] tgt_addr_q;
    logic [DATA_W-1:0] tgt_data_q;
    logic [DATA_W-1:0] rd_q;
    logic [1:0]        step_q;
    logic [PW-1:0]     poll_cnt_q;

    logic              tmr_load;
    logic [TW-1:0]     tmr_val;
    logic              tmr_zero;
    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] cmd_data;
    logic              needs_erase, msb_ok, all_ok;
    logic              timeout_hit;
    logic              read_state;

    fbp_timer #(.W(TW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_zero)
    );

    fbp_cmd_gen #(.ADDR_W(ADDR_W)) u_cmd (
        .step     (step_q),
        .tgt_addr (tgt_addr_q),
        .tgt_data (tgt_data_q),
        .cyc_addr (cmd_addr),
        .cyc_data (cmd_data)
    );

    fbp_byte_cmp u_cmp (
        .want        (tgt_data_q),
        .seen        (rd_q),
        .needs_erase (needs_erase),
        .msb_ok      (msb_ok),
        .all_ok      (all_ok)
    );

    assign timeout_hit = (poll_cnt_q >= TO_LIM);
    assign read_state  = (state_q == ST_PRE_RD) || (state_q == ST_POLL_RD) ||
                         (state_q == ST_VFY_RD);

    // State register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            err_q      <= ERR_NONE;
            tgt_addr_q <= '0;
            tgt_data_q <= '0;
            rd_q       <= '0;
            step_q     <= '0;
            poll_cnt_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_valid) begin
                tgt_addr_q <= req_addr;
                tgt_data_q <= req_data;
                err_q      <= ERR_NONE;
            end
            if (read_state && tmr_zero) begin
                rd_q <= fl_dq_in;
            end
            if (state_q == ST_PRE_CHK) begin
                step_q <= '0;
                if (needs_erase) err_q <= ERR_NEEDS_ERASE;
            end
            if (state_q == ST_WR_REC && tmr_zero) begin
                if (step_q == LAST_STEP) poll_cnt_q <= '0;
                else                     step_q     <= step_q + 2'd1;
            end
            if ((state_q == ST_POLL_RD || state_q == ST_POLL_EVAL) && !timeout_hit) begin
                poll_cnt_q <= poll_cnt_q + 1'b1;
            end
            if (state_q == ST_POLL_EVAL && !msb_ok && timeout_hit) begin
                err_q <= ERR_TIMEOUT;
            end
            if (state_q == ST_VFY_EVAL && !all_ok) begin
                err_q <= ERR_VERIFY;
            end
        end
    end

    // Next state and timer loading
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d  = ST_PRE_RD;
                    tmr_load = 1'b1;
                    tmr_val  = RD_LOAD;
                end
            end
            ST_PRE_RD: begin
                if (tmr_zero) state_d = ST_PRE_CHK;
            end
            ST_PRE_CHK: begin
                state_d = needs_erase ? ST_FAIL : ST_WR_SETUP;
            end
            ST_WR_SETUP: begin
                state_d  = ST_WR_PULSE;
                tmr_load = 1'b1;
                tmr_val  = LO_LOAD;
            end
            ST_WR_PULSE: begin
                if (tmr_zero) begin
                    state_d  = ST_WR_REC;
                    tmr_load = 1'b1;
                    tmr_val  = HI_LOAD;
                end
            end
            ST_WR_REC: begin
                if (tmr_zero) begin
                    if (step_q == LAST_STEP) begin
                        state_d  = ST_POLL_RD;
                        tmr_load = 1'b1;
                        tmr_val  = RD_LOAD;
                    end else begin
                        state_d = ST_WR_SETUP;
                    end
                end
            end
            ST_POLL_RD: begin
                if (tmr_zero) state_d = ST_POLL_EVAL;
            end
            ST_POLL_EVAL: begin
                if (msb_ok) begin
                    state_d  = ST_VFY_RD;
                    tmr_load = 1'b1;
                    tmr_val  = RD_LOAD;
                end else if (timeout_hit) begin
                    state_d = ST_FAIL;
                end else begin
                    state_d  = ST_POLL_RD;
                    tmr_load = 1'b1;
                    tmr_val  = RD_LOAD;
                end
            end
            ST_VFY_RD: begin
                if (tmr_zero) state_d = ST_VFY_EVAL;
            end
            ST_VFY_EVAL: begin
                state_d = all_ok ? ST_DONE : ST_FAIL;
            end
            ST_DONE, ST_FAIL: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Outputs decoded from the registered state
    always_comb begin
        fl_ce_n   = 1'b1;
        fl_oe_n   = 1'b1;
        fl_we_n   = 1'b1;
        fl_addr   = tgt_addr_q;
        fl_dq_out = cmd_data;
        fl_dq_oe  = 1'b0;
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_DONE);
        err       = (state_q == ST_FAIL);
        err_code  = (state_q == ST_FAIL) ? err_q : ERR_NONE;
        unique case (state_q)
            ST_PRE_RD, ST_POLL_RD, ST_VFY_RD: begin
                fl_ce_n = 1'b0;
                fl_oe_n = 1'b0;
            end
            ST_PRE_CHK, ST_POLL_EVAL, ST_VFY_EVAL: begin
                fl_ce_n = 1'b0;
            end
            ST_WR_SETUP, ST_WR_REC: begin
                fl_ce_n  = 1'b0;
                fl_addr  = cmd_addr;
                fl_dq_oe = 1'b1;
            end
            ST_WR_PULSE: begin
                fl_ce_n  = 1'b0;
                fl_we_n  = 1'b0;
                fl_addr  = cmd_addr;
                fl_dq_oe = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/fbp_checker.sv
module fbp_checker #(
    parameter int unsigned ADDR_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic [1:0]        err_code,
    input logic              fl_ce_n,
    input logic              fl_oe_n,
    input logic              fl_we_n,
    input logic [ADDR_W-1:0] fl_addr,
    input logic [7:0]        fl_dq_out,
    input logic              fl_dq_oe
);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (fl_ce_n && fl_oe_n && fl_we_n && !fl_dq_oe));

    assert_we_qualified_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |-> (!fl_ce_n && fl_oe_n && fl_dq_oe));

    assert_pulse_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dq_out)));

    assert_rise_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_we_n) |-> (fl_dq_oe && $stable(fl_addr) && $stable(fl_dq_out)));

    assert_no_contention_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fl_dq_oe |-> fl_oe_n);

    assert_status_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, err}));

    assert_status_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |=> (!done && !err && !busy));

    assert_err_coded_R12: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (err_code != 2'd0));

    assert_done_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (err_code == 2'd0));

endmodule

bind flash_byte_prog fbp_checker #(.ADDR_W(ADDR_W)) u_fbp_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .err_code  (err_code),
    .fl_ce_n   (fl_ce_n),
    .fl_oe_n   (fl_oe_n),
    .fl_we_n   (fl_we_n),
    .fl_addr   (fl_addr),
    .fl_dq_out (fl_dq_out),
    .fl_dq_oe  (fl_dq_oe)
);

// File: tb/flash_byte_prog_test.sv
module flash_byte_prog_test;

    localparam int CLK_PERIOD = 10;
    localparam int RD = 3;
    localparam int WL = 2;
    localparam int WH = 2;
    localparam int TO = 300;
    localparam int PROG_T = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_data = '0;
    logic        busy, done, err;
    logic [1:0]  err_code;
    logic        fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe;
    logic [16:0] fl_addr;
    logic [7:0]  fl_dq_out, fl_dq_in;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_byte_prog #(
        .ADDR_W(17), .READ_CYC(RD), .WE_LOW_CYC(WL),
        .WE_HIGH_CYC(WH), .TIMEOUT_CYC(TO)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_data(req_data), .busy(busy), .done(done), .err(err), .err_code(err_code),
        .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n), .fl_addr(fl_addr),
        .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in)
    );

    // Behavioural flash: everything below is written only by this model
    logic [7:0]  mem [256];
    logic        prog_busy = 1'b0;
    int          prog_left = 0;
    logic [7:0]  last_d = '0;
    int          seq_st = 0;
    logic        prev_we = 1'b1;
    logic        prev_oe = 1'b1;
    logic [16:0] fall_addr = '0;
    int          lo_run = 0, hi_run = 0;
    int          we_falls = 0, oe_falls = 0, wr_total = 0;
    int          width_bad = 0, gap_bad = 0, hold_bad = 0, contention = 0;
    logic [16:0] log_addr [8];
    logic [7:0]  log_data [8];
    int          pre_ack = 0;

    // Written only by the bench
    int          pre_req = 0;
    logic [7:0]  pre_idx = '0, pre_val = '0;
    logic        stuck = 1'b0, corrupt = 1'b0;

    assign fl_dq_in = prog_busy ? {~last_d[7], 7'h15} : mem[fl_addr[7:0]];

    always @(negedge clk) begin
        if (pre_req != pre_ack) begin
            mem[pre_idx] = pre_val;
            pre_ack = pre_req;
        end
        if (rst_n) begin
            if (fl_dq_oe && !fl_oe_n) contention++;
            if (prev_oe && !fl_oe_n && !fl_ce_n) oe_falls++;
            if (prev_we && !fl_we_n) begin
                we_falls++;
                if (seq_st != 0 && hi_run != WH + 1) gap_bad++;
                fall_addr = fl_addr;
                lo_run = 1;
            end else if (!fl_we_n) begin
                lo_run++;
                if (fl_addr != fall_addr) hold_bad++;
            end else if (!prev_we && fl_we_n) begin
                if (lo_run != WL) width_bad++;
                if (!fl_dq_oe || fl_addr != fall_addr) hold_bad++;
                hi_run = 1;
                log_addr[wr_total % 8] = fall_addr;
                log_data[wr_total % 8] = fl_dq_out;
                wr_total++;
                case (seq_st)
                    0: seq_st = (fall_addr[11:0] == 12'h555 && fl_dq_out == 8'hAA) ? 1 : 0;
                    1: seq_st = (fall_addr[11:0] == 12'h2AA && fl_dq_out == 8'h55) ? 2 : 0;
                    2: seq_st = (fall_addr[11:0] == 12'h555 && fl_dq_out == 8'hA0) ? 3 : 0;
                    default: begin
                        mem[fall_addr[7:0]] = (mem[fall_addr[7:0]] & fl_dq_out) ^ {7'd0, corrupt};
                        last_d    = fl_dq_out;
                        prog_busy = 1'b1;
                        prog_left = PROG_T;
                        seq_st    = 0;
                    end
                endcase
            end else begin
                hi_run++;
            end
            if (prog_busy && !stuck && !(!prev_we && fl_we_n)) begin
                if (prog_left > 0) prog_left--;
                else prog_busy = 1'b0;
            end
            prev_we = fl_we_n;
            prev_oe = fl_oe_n;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic preload(input logic [7:0] idx, input logic [7:0] val);
        pre_idx = idx;
        pre_val = val;
        pre_req++;
        @(negedge clk); #1;
    endtask

    task automatic run_txn(input logic [16:0] a, input logic [7:0] d, input bit inject,
                           output logic [1:0] code, output int lat);
        req_valid = 1'b1;
        req_addr  = a;
        req_data  = d;
        lat = 0;
        forever begin
            @(negedge clk); #1;
            lat++;
            req_valid = 1'b0;
            if (inject && lat == 5) begin
                req_valid = 1'b1;
                req_addr  = 17'h00077;
                req_data  = 8'h00;
            end
            if (done || err) break;
            if (lat > 20000) break;
        end
        req_valid = 1'b0;
        code = err ? err_code : 2'd0;
        chk(!(done && err), "R12 exclusive status", {done, err}, 1);
        @(negedge clk); #1;
        chk(!busy && !done && !err, "R12 single pulse, busy low after", {busy, done, err}, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        fails++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [1:0] code;
        int         lat, f0, w0;
        logic [7:0] old, nw;
        logic [16:0] a;

        repeat (4) @(negedge clk);
        #1;
        chk(fl_ce_n && fl_oe_n && fl_we_n && !fl_dq_oe, "R1 pins in reset",
            {fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe}, 4'b1110);
        chk(!busy && !done && !err, "R1 status in reset", {busy, done, err}, 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(fl_ce_n && !fl_dq_oe && !busy, "R1 idle after reset", {fl_ce_n, fl_dq_oe, busy}, 3'b100);

        // Sweep every new byte against two stored patterns
        for (int oi = 0; oi < 2; oi++) begin
            old = (oi == 0) ? 8'hA5 : 8'h3C;
            for (int n = 0; n < 256; n++) begin
                nw = 8'(n);
                a  = {1'(oi), 8'(n ^ 8'h5A), 8'(n)};
                preload(8'(n), old);
                f0 = we_falls;
                w0 = wr_total;
                run_txn(a, nw, 1'b0, code, lat);
                if ((nw & ~old) != 8'h00) begin
                    chk(code == 2'd1, "R2 needs-erase code", code, 1);
                    chk(lat == RD + 2, "R2 rejection latency", lat, RD + 2);
                    chk(we_falls == f0, "R2 no write pulse", we_falls - f0, 0);
                    chk(mem[8'(n)] == old, "R2 memory untouched", mem[8'(n)], old);
                end else begin
                    chk(code == 2'd0, "R8 success code", code, 0);
                    chk(mem[8'(n)] == nw, "R8 memory holds new byte", mem[8'(n)], nw);
                    chk(we_falls - f0 == 4, "R3 four write pulses", we_falls - f0, 4);
                    chk(log_addr[w0 % 8] == 17'h00555 && log_data[w0 % 8] == 8'hAA,
                        "R3 first unlock write", log_data[w0 % 8], 8'hAA);
                    chk(log_addr[(w0 + 1) % 8] == 17'h002AA && log_data[(w0 + 1) % 8] == 8'h55,
                        "R3 second unlock write", log_data[(w0 + 1) % 8], 8'h55);
                    chk(log_addr[(w0 + 2) % 8] == 17'h00555 && log_data[(w0 + 2) % 8] == 8'hA0,
                        "R3 program command write", log_data[(w0 + 2) % 8], 8'hA0);
                    chk(log_addr[(w0 + 3) % 8] == a && log_data[(w0 + 3) % 8] == nw,
                        "R3 target write", log_addr[(w0 + 3) % 8], a);
                    chk(lat >= 4 * (1 + WL + WH) + PROG_T, "R7 waits out programming",
                        lat, 4 * (1 + WL + WH) + PROG_T);
                end
            end
        end

        // Polling read count on one success
        preload(8'h40, 8'hFF);
        f0 = oe_falls;
        run_txn(17'h10040, 8'h81, 1'b0, code, lat);
        chk(code == 2'd0, "R8 success 0x81", code, 0);
        chk(oe_falls - f0 >= 4, "R7 repeated reads with OE gaps", oe_falls - f0, 4);

        // Completion never reported
        preload(8'h10, 8'hFF);
        stuck = 1'b1;
        run_txn(17'h00010, 8'h12, 1'b0, code, lat);
        chk(code == 2'd2, "R10 timeout code", code, 2);
        chk(lat >= TO + 4 * (1 + WL + WH), "R10 timeout not early", lat, TO + 4 * (1 + WL + WH));
        stuck = 1'b0;
        repeat (PROG_T + 5) @(negedge clk);
        #1;

        // Bit 7 matches but the byte does not
        preload(8'h20, 8'hFF);
        corrupt = 1'b1;
        run_txn(17'h00020, 8'hF0, 1'b0, code, lat);
        chk(code == 2'd3, "R9 verify mismatch code", code, 3);
        corrupt = 1'b0;

        // Request while busy
        preload(8'h77, 8'hFF);
        preload(8'h30, 8'hFF);
        f0 = we_falls;
        run_txn(17'h00030, 8'h5A, 1'b1, code, lat);
        chk(code == 2'd0, "R11 first request completes", code, 0);
        chk(we_falls - f0 == 4, "R11 no extra writes", we_falls - f0, 4);
        repeat (3) @(negedge clk);
        #1;
        chk(!busy && we_falls - f0 == 4, "R11 ignored request never started", we_falls - f0, 4);
        chk(mem[8'h77] == 8'hFF, "R11 ignored location untouched", mem[8'h77], 8'hFF);

        chk(width_bad == 0, "R4 WE low width", width_bad, 0);
        chk(gap_bad == 0, "R5 WE high gap", gap_bad, 0);
        chk(hold_bad == 0, "R5 address and data hold", hold_bad, 0);
        chk(contention == 0, "R6 bus contention", contention, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule